// File: doc/BRIEF.md
# Atomic Chunked CSR Multiplexer

This block connects a narrow control/status register bus to a small set of registers that are each wider than the bus. Every register is cut into bus-width chunks that sit at consecutive bus addresses inside a fixed-size address window. Software sees a register as several bytes. The register itself only ever sees whole-value reads and whole-value writes.

Atomicity comes from two shadow buffers per register. A read of the lowest chunk samples the full register into a read shadow in one cycle. The higher chunks are then served from that snapshot. Writes to the lower chunks only collect bytes in a write shadow. The write to the highest chunk delivers the complete assembled value to the register in a single strobe.

In the default configuration the bus is 8 bits wide with a 3-bit address. It serves two 24-bit registers in 4-address windows: register 0 is readable and writable, and register 1 is read-only.

Top module: `csr_chunk_mux`

## Requirements
- R1: While reset is asserted and right after it, `bus_rd_data` is 0, all bits of `elem_rd_stb` and `elem_wr_stb` are 0, and `elem_wr_data` is 0.
- R2: Register i occupies the window starting at address i*4. Chunk k of that register sits at window offset k and carries register bits [8k+7:8k]. Window offset 3 is unmapped.
- R3: A bus read of offset 0 of a readable register drives that register's `elem_rd_stb` high in the same cycle as the bus strobe. No other bus read raises any `elem_rd_stb` bit.
- R4: Reads of offsets 1 and 2 return the bytes captured at the most recent offset-0 read of the same register. Later changes of the register value do not alter them, and neither do reads of other registers.
- R5: A bus write to a lower chunk (offset 0 or 1) of a writable register only stores the byte in that register's write buffer. No `elem_wr_stb` bit is raised.
- R6: A bus write to the top chunk (offset 2) of a writable register raises that register's `elem_wr_stb` for exactly one cycle, starting in the next cycle. At the same time its `elem_wr_data` slice becomes {written byte, buffered offset-1 byte, buffered offset-0 byte}, and the value holds until the next commit. Buffered bytes persist across commits.
- R7: Access modes take 2 bits per register in `REG_ACCESS`: bit 0 means readable and bit 1 means writable. The default is register 0 = 2'b11 and register 1 = 2'b01. Writes to a non-writable register are ignored: no strobe, and its `elem_wr_data` slice stays 0.
- R8: Unmapped addresses read as 0. Writes to them raise no strobe and leave all write buffers unchanged.
- R9: Read data appears on `bus_rd_data` in the cycle after the read strobe. In any cycle that follows a cycle without a read strobe, `bus_rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_rd_stb | input | 1 | Bus read strobe |
| bus_rd_data | output | DATA_W | Bus read data, one cycle after the strobe |
| bus_wr_stb | input | 1 | Bus write strobe |
| bus_wr_data | input | DATA_W | Bus write data |
| elem_rd_data | input | NUM_REGS*REG_W | Live register values, register i in slice i |
| elem_rd_stb | output | NUM_REGS | Per-register read strobe |
| elem_wr_data | output | NUM_REGS*REG_W | Committed write values, register i in slice i |
| elem_wr_stb | output | NUM_REGS | Per-register one-cycle write strobe |

## Verification
The hardest case to reach from the ports is a register whose live value changes between the snapshot read and the reads of its upper chunks. The bench reads offset 0 and then rewrites the value it drives into `elem_rd_data`. It then reads offsets 1 and 2, and expects the old bytes while offset 0 already shows the new one. On the write side, a partial sequence skips offset 1. The bench then checks that the commit reuses the byte buffered earlier, and that a write to the unmapped slot between two commits does not disturb that buffer.

// File: rtl/csr_mux_pkg.sv
package csr_mux_pkg;

  // Bit 0: readable, bit 1: writable.
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_RO   = 2'b01,
    ACC_WO   = 2'b10,
    ACC_RW   = 2'b11
  } acc_e;

  function automatic logic acc_can_read(logic [1:0] mode);
    return mode[0];
  endfunction

  function automatic logic acc_can_write(logic [1:0] mode);
    return mode[1];
  endfunction

endpackage

// File: rtl/csr_mux_addr_dec.sv
module csr_mux_addr_dec #(
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 2,
  parameter int CHUNKS   = 3,
  parameter int WIN_LOG2 = 2,
  localparam int IDX_W   = ADDR_W - WIN_LOG2
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] reg_sel,
  output logic [WIN_LOG2-1:0] chunk,
  output logic                is_first,
  output logic                is_last
);

  logic [IDX_W-1:0] idx;
  logic             hit;

  always_comb begin
    idx      = addr[ADDR_W-1:WIN_LOG2];
    chunk    = addr[WIN_LOG2-1:0];
    hit      = (int'(idx) < NUM_REGS) && (int'(chunk) < CHUNKS);
    is_first = (int'(chunk) == 0);
    is_last  = (int'(chunk) == CHUNKS - 1);
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign reg_sel[i] = hit && (int'(idx) == i);
  end

endmodule

// File: rtl/csr_mux_rd_slot.sv
// Per-register read side: snapshot of upper chunks taken at the chunk-0 read.
// CHUNKS must be at least 2.
module csr_mux_rd_slot #(
  parameter int DATA_W   = 8,
  parameter int CHUNKS   = 3,
  parameter int WIN_LOG2 = 2,
  localparam int REG_W   = DATA_W * CHUNKS,
  localparam int UP_W    = DATA_W * (CHUNKS - 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                rd_stb,
  input  logic                is_first,
  input  logic [WIN_LOG2-1:0] chunk,
  input  logic [REG_W-1:0]    reg_val,
  output logic                rd_strobe,
  output logic [DATA_W-1:0]   rd_byte
);

  logic [UP_W-1:0] snap_q;
  logic [UP_W-1:0] snap_d;
  logic            snap_en;

  always_comb begin
    rd_strobe = rd_stb && sel && is_first;
    snap_en   = rd_strobe;
    snap_d    = reg_val[REG_W-1:DATA_W];
  end

  always_comb begin
    rd_byte = '0;
    if (is_first) begin
      rd_byte = reg_val[DATA_W-1:0];
    end else begin
      for (int k = 1; k < CHUNKS; k++) begin
        if (int'(chunk) == k) rd_byte = snap_q[(k-1)*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_en) begin
      snap_q <= snap_d;
    end
  end

endmodule

// File: rtl/csr_mux_wr_slot.sv
// Per-register write side: lower chunks buffered, top chunk commits.
// CHUNKS must be at least 2.
module csr_mux_wr_slot #(
  parameter int DATA_W   = 8,
  parameter int CHUNKS   = 3,
  parameter int WIN_LOG2 = 2,
  localparam int REG_W   = DATA_W * CHUNKS,
  localparam int LO_W    = DATA_W * (CHUNKS - 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                wr_stb,
  input  logic                is_last,
  input  logic [WIN_LOG2-1:0] chunk,
  input  logic [DATA_W-1:0]   wr_byte,
  output logic [REG_W-1:0]    reg_wdata,
  output logic                reg_wstb
);

  logic [LO_W-1:0]  buf_q, buf_d;
  logic             buf_en;
  logic [REG_W-1:0] val_q, val_d;
  logic             commit;
  logic             stb_q;

  always_comb begin
    commit = wr_stb && sel && is_last;
    buf_en = wr_stb && sel && !is_last;
    buf_d  = buf_q;
    for (int k = 0; k < CHUNKS - 1; k++) begin
      if (int'(chunk) == k) buf_d[k*DATA_W +: DATA_W] = wr_byte;
    end
    val_d  = {wr_byte, buf_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      val_q <= '0;
      stb_q <= 1'b0;
    end else begin
      if (buf_en) buf_q <= buf_d;
      if (commit) val_q <= val_d;
      stb_q <= commit;
    end
  end

  assign reg_wdata = val_q;
  assign reg_wstb  = stb_q;

endmodule

// File: rtl/csr_chunk_mux.sv
module csr_chunk_mux
  import csr_mux_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 2,
  parameter int CHUNKS   = 3,
  parameter int WIN_LOG2 = 2,
  parameter logic [2*NUM_REGS-1:0] REG_ACCESS = {ACC_RO, ACC_RW},
  localparam int REG_W   = DATA_W * CHUNKS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_rd_stb,
  output logic [DATA_W-1:0]         bus_rd_data,
  input  logic                      bus_wr_stb,
  input  logic [DATA_W-1:0]         bus_wr_data,
  input  logic [NUM_REGS*REG_W-1:0] elem_rd_data,
  output logic [NUM_REGS-1:0]       elem_rd_stb,
  output logic [NUM_REGS*REG_W-1:0] elem_wr_data,
  output logic [NUM_REGS-1:0]       elem_wr_stb
);

  logic [NUM_REGS-1:0] reg_sel;
  logic [WIN_LOG2-1:0] chunk;
  logic                is_first;
  logic                is_last;
  logic [DATA_W-1:0]   slot_byte [NUM_REGS];
  logic [DATA_W-1:0]   rd_d, rd_q;

  csr_mux_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .CHUNKS(CHUNKS), .WIN_LOG2(WIN_LOG2)
  ) i_dec (
    .addr(bus_addr), .reg_sel(reg_sel), .chunk(chunk),
    .is_first(is_first), .is_last(is_last)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (acc_can_read(REG_ACCESS[2*i +: 2])) begin : g_rd
      csr_mux_rd_slot #(
        .DATA_W(DATA_W), .CHUNKS(CHUNKS), .WIN_LOG2(WIN_LOG2)
      ) i_rd (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel[i]), .rd_stb(bus_rd_stb),
        .is_first(is_first), .chunk(chunk),
        .reg_val(elem_rd_data[i*REG_W +: REG_W]),
        .rd_strobe(elem_rd_stb[i]), .rd_byte(slot_byte[i])
      );
    end else begin : g_no_rd
      assign elem_rd_stb[i] = 1'b0;
      assign slot_byte[i]   = '0;
    end

    if (acc_can_write(REG_ACCESS[2*i +: 2])) begin : g_wr
      csr_mux_wr_slot #(
        .DATA_W(DATA_W), .CHUNKS(CHUNKS), .WIN_LOG2(WIN_LOG2)
      ) i_wr (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel[i]), .wr_stb(bus_wr_stb),
        .is_last(is_last), .chunk(chunk), .wr_byte(bus_wr_data),
        .reg_wdata(elem_wr_data[i*REG_W +: REG_W]), .reg_wstb(elem_wr_stb[i])
      );
    end else begin : g_no_wr
      assign elem_wr_data[i*REG_W +: REG_W] = '0;
      assign elem_wr_stb[i]                 = 1'b0;
    end
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (bus_rd_stb && reg_sel[i]) rd_d = rd_d | slot_byte[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign bus_rd_data = rd_q;

endmodule

// File: rtl/csr_chunk_mux_chk.sv
module csr_chunk_mux_chk
  import csr_mux_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 2,
  parameter int CHUNKS   = 3,
  parameter int WIN_LOG2 = 2,
  parameter logic [2*NUM_REGS-1:0] REG_ACCESS = {ACC_RO, ACC_RW}
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_rd_stb,
  input logic [DATA_W-1:0]   bus_rd_data,
  input logic                bus_wr_stb,
  input logic [NUM_REGS-1:0] elem_rd_stb,
  input logic [NUM_REGS-1:0] elem_wr_stb
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3: a register read strobe only accompanies a chunk-0 bus read
  p_rd_stb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|elem_rd_stb) |-> (bus_rd_stb && (int'(bus_addr[WIN_LOG2-1:0]) == 0)));

  p_rd_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(elem_rd_stb));

  // R5/R6: commit strobe follows a top-chunk bus write
  p_wr_commit_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (|elem_wr_stb)) |->
      ($past(bus_wr_stb) && (int'($past(bus_addr[WIN_LOG2-1:0])) == CHUNKS - 1)));

  p_wr_stb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(elem_wr_stb));

  // R9: no read strobe in the previous cycle means zero read data
  p_idle_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(bus_rd_stb)) |-> (bus_rd_data == '0));

  // R7: non-writable registers never see a write strobe
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ro
    if (!acc_can_write(REG_ACCESS[2*i +: 2])) begin : g_chk
      p_ro_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_stb |=> !elem_wr_stb[i]);
    end
  end

endmodule

bind csr_chunk_mux csr_chunk_mux_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .CHUNKS(CHUNKS),
  .WIN_LOG2(WIN_LOG2), .REG_ACCESS(REG_ACCESS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_stb(bus_rd_stb),
  .bus_rd_data(bus_rd_data), .bus_wr_stb(bus_wr_stb),
  .elem_rd_stb(elem_rd_stb), .elem_wr_stb(elem_wr_stb)
);

// File: tb/test_csr_chunk_mux.sv
module test_csr_chunk_mux;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd_stb = 1'b0;
  logic [7:0]  bus_rd_data;
  logic        bus_wr_stb = 1'b0;
  logic [7:0]  bus_wr_data = '0;
  logic [47:0] elem_rd_data = '0;
  logic [1:0]  elem_rd_stb;
  logic [47:0] elem_wr_data;
  logic [1:0]  elem_wr_stb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_chunk_mux i_csr_chunk_mux (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_stb(bus_rd_stb),
    .bus_rd_data(bus_rd_data), .bus_wr_stb(bus_wr_stb), .bus_wr_data(bus_wr_data),
    .elem_rd_data(elem_rd_data), .elem_rd_stb(elem_rd_stb),
    .elem_wr_data(elem_wr_data), .elem_wr_stb(elem_wr_stb)
  );

  // {address, expected byte}; register 0 = C3B2A1, register 1 = F6E5D4 (R2)
  localparam logic [10:0] RD_VEC [8] = '{
    {3'd0, 8'hA1}, {3'd1, 8'hB2}, {3'd2, 8'hC3}, {3'd3, 8'h00},
    {3'd4, 8'hD4}, {3'd5, 8'hE5}, {3'd6, 8'hF6}, {3'd7, 8'h00}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [1:0] stb_seen,
                          output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_stb = 1'b1;
    #1 stb_seen = elem_rd_stb;
    @(negedge clk);
    bus_rd_stb = 1'b0;
    d = bus_rd_data;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] v,
                           output logic [1:0] stb_seen, output logic [47:0] wd);
    @(negedge clk);
    bus_addr = a; bus_wr_stb = 1'b1; bus_wr_data = v;
    @(negedge clk);
    bus_wr_stb = 1'b0;
    stb_seen = elem_wr_stb;
    wd = elem_wr_data;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0]  s;
    logic [7:0]  d;
    logic [47:0] wd;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 rd_data", {56'd0, bus_rd_data}, 64'd0);
    chk("R1 strobes", {60'd0, elem_rd_stb, elem_wr_stb}, 64'd0);
    chk("R1 wr_data", {16'd0, elem_wr_data}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {56'd0, bus_rd_data}, 64'd0);

    // R2: address map walk
    elem_rd_data = {24'hF6E5D4, 24'hC3B2A1};
    for (int i = 0; i < 8; i++) begin
      bus_read(RD_VEC[i][10:8], s, d);
      chk($sformatf("R2 addr %0d", i), {56'd0, d}, {56'd0, RD_VEC[i][7:0]});
    end

    // R9: idle cycle after a read gives zero
    @(negedge clk);
    chk("R9 idle rd_data", {56'd0, bus_rd_data}, 64'd0);

    // R3: read strobe placement
    bus_read(3'd0, s, d); chk("R3 chunk0 reg0", {62'd0, s}, 64'd1);
    bus_read(3'd1, s, d); chk("R3 chunk1 no stb", {62'd0, s}, 64'd0);
    bus_read(3'd4, s, d); chk("R3 chunk0 reg1", {62'd0, s}, 64'd2);
    bus_read(3'd3, s, d); chk("R3 unmapped no stb", {62'd0, s}, 64'd0);
    chk("R8 unmapped read", {56'd0, d}, 64'd0);

    // R4: snapshot survives live change and other-register reads
    bus_read(3'd0, s, d); chk("R4 low byte", {56'd0, d}, 64'hA1);
    elem_rd_data = {24'h998877, 24'h112233};
    bus_read(3'd4, s, d); chk("R4 other reg", {56'd0, d}, 64'h77);
    bus_read(3'd1, s, d); chk("R4 old chunk1", {56'd0, d}, 64'hB2);
    bus_read(3'd2, s, d); chk("R4 old chunk2", {56'd0, d}, 64'hC3);
    bus_read(3'd0, s, d); chk("R4 new low", {56'd0, d}, 64'h33);
    bus_read(3'd1, s, d); chk("R4 new chunk1", {56'd0, d}, 64'h22);
    chk("R9 one-cycle latency", {56'd0, d}, 64'h22);

    // R5/R6: full write sequence
    bus_write(3'd0, 8'h11, s, wd); chk("R5 chunk0 no stb", {62'd0, s}, 64'd0);
    bus_write(3'd1, 8'h22, s, wd); chk("R5 chunk1 no stb", {62'd0, s}, 64'd0);
    bus_write(3'd2, 8'h33, s, wd);
    chk("R6 commit stb", {62'd0, s}, 64'd1);
    chk("R6 commit data", {40'd0, wd[23:0]}, 64'h332211);
    @(negedge clk);
    chk("R6 one-cycle pulse", {62'd0, elem_wr_stb}, 64'd0);
    chk("R6 data holds", {40'd0, elem_wr_data[23:0]}, 64'h332211);

    // R6: partial sequence reuses buffered chunk1
    bus_write(3'd0, 8'h44, s, wd);
    bus_write(3'd2, 8'h55, s, wd);
    chk("R6 partial data", {40'd0, wd[23:0]}, 64'h552244);

    // R8: unmapped writes leave buffers untouched
    bus_write(3'd3, 8'hEE, s, wd); chk("R8 unmapped no stb", {62'd0, s}, 64'd0);
    bus_write(3'd7, 8'hEE, s, wd); chk("R8 unmapped2 no stb", {62'd0, s}, 64'd0);
    bus_write(3'd2, 8'h66, s, wd);
    chk("R8 buffers intact", {40'd0, wd[23:0]}, 64'h662244);

    // R7: read-only register ignores writes
    bus_write(3'd4, 8'hAA, s, wd); chk("R7 ro chunk0", {62'd0, s}, 64'd0);
    bus_write(3'd5, 8'hBB, s, wd); chk("R7 ro chunk1", {62'd0, s}, 64'd0);
    bus_write(3'd6, 8'hCC, s, wd); chk("R7 ro commit", {62'd0, s}, 64'd0);
    @(negedge clk);
    chk("R7 ro no strobe", {62'd0, elem_wr_stb}, 64'd0);
    chk("R7 ro data zero", {40'd0, elem_wr_data[47:24]}, 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule